// File: doc/BRIEF.md
# Reload Event Counter

A down-counting timer with a reload register. It takes its decrement from one of two sources. The first is a prescaled system clock, divided by 4, 16, 64 or 256. The second is an external event pin. The pin is synchronized and edge-detected inside the block, and the edge that counts is chosen by software. When the pin is the source, the prescaler plays no part: each qualified pin edge takes exactly one off the count.

Software drives the block through a small register port. It can write a control word and a reload value, and it can read back the control word, the reload value, the live count and a cause register. When the count runs out, the block does three things. It records an end-of-count cause. It asserts the interrupt request if interrupts are enabled. Then it either reloads and keeps going, or stops in one-shot mode. Reading the cause register returns the pending causes and clears them in the same access.

Top module: `evt_reload_timer`

## Requirements
- R1: After reset the control word, reload value, count and cause register are all zero, and `irq_o` is low.
- R2: Register map, with addresses on `wr_addr_i`/`rd_addr_i`: 0 is control, 1 is reload, 2 is count (read only), 3 is cause (read only). Control bits: [0] enable, [1] source (0 clock, 1 pin), [2] edge (0 rising, 1 falling), [3] continuous (1) or one-shot (0), [4] interrupt enable, [6:5] prescale select. Writes to addresses 2 and 3 have no effect.
- R3: A control write that takes enable from 0 to 1 loads the count from the reload register in the same clock edge.
- R4: In clock mode, prescale select 0/1/2/3 divides by 4/16/64/256. The first decrement lands N cycles after the enabling write, and the next ones follow every N cycles.
- R5: In pin mode the prescaler is bypassed. The count changes only on pin edges and stays fixed when the pin is idle.
- R6: Only the selected pin edge decrements the count. The opposite edge is ignored.
- R7: Suppose the pin changes just before clock edge 1. The count then changes at clock edge 3 and not earlier.
- R8: A decrement while the count is 1 (or 0) is end-of-count. It sets cause bit 0. In continuous mode it reloads the count from the reload register.
- R9: End-of-count in one-shot mode leaves the count at 0 and clears the enable bit. Later pin edges do not change the count.
- R10: Reading address 3 returns the cause bits and clears them. An end-of-count that occurs in the same cycle as that read stays pending.
- R11: `irq_o` is the OR of the pending cause bits whose interrupt is enabled. It drops after a clearing read if no new cause has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_pin_i | input | 1 | External event pin, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address |
| wr_data_i | input | 16 | Write data |
| rd_en_i | input | 1 | Register read strobe (clears causes at address 3) |
| rd_addr_i | input | 2 | Read address |
| rd_data_o | output | 16 | Read data, combinational from the address |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench times the pin latency to the exact clock edge. A design with one synchronizer stage too few or too many moves the count one cycle early or late. The bench also puts a cause read in the same cycle as end-of-count. A clear that beats the set would lose that interrupt, and the read that follows would show zero. Opposite-polarity edges, idle pins in pin mode and writes to read-only addresses are all checked at the count output, so a design that counts both edges or leaks prescaler ticks into pin mode shows a wrong count. One-shot expiry is checked through the control readback, where enable must have cleared.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned NCAUSE = 1;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 2'd0,
    A_RELD  = 2'd1,
    A_COUNT = 2'd2,
    A_CAUSE = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [1:0] psel;
    logic       ie;
    logic       cont;
    logic       pol;
    logic       src;
    logic       en;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/evt_sync_edge.sv
module evt_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic fall_sel_i,
  output logic evt_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign evt_o = fall_sel_i ? (prev_q & ~sync_q[STAGES-1])
                            : (~prev_q & sync_q[STAGES-1]);
endmodule

// File: rtl/evt_prescaler.sv
module evt_prescaler #(
  parameter int unsigned NSEL = 4,
  parameter int unsigned STEP = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    run_i,
  input  logic [$clog2(NSEL)-1:0] sel_i,
  output logic                    tick_o
);
  localparam int unsigned PRE_W = STEP * NSEL;

  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] lim;
  logic [PRE_W-1:0] lim_tab [NSEL];

  // divide ratio = 2^(STEP*(sel+1))
  for (genvar g = 0; g < NSEL; g++) begin : g_lim
    assign lim_tab[g] = PRE_W'((1 << (STEP * (g + 1))) - 1);
  end

  assign lim    = lim_tab[sel_i];
  assign tick_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/evt_cause_flags.sv
module evt_cause_flags #(
  parameter int unsigned N = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] flags_o,
  output logic         irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_o <= '0;
    else         flags_o <= set_i | (flags_o & {N{~clr_i}}); // set beats clear
  end

  assign irq_o = |(flags_o & mask_i);
endmodule

// File: rtl/evt_reload_timer.sv
module evt_reload_timer
  import evt_timer_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_pin_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [W-1:0]      wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [W-1:0]      rd_data_o,
  output logic              irq_o
);
  ctrl_t             ctrl_q;
  logic [W-1:0]      reld_q;
  logic [W-1:0]      cnt_q;
  logic [NCAUSE-1:0] cause;
  logic              pin_evt, pre_tick, ctrl_wr, en_rise, dec, term, eoc_set, cause_rd;

  assign ctrl_wr  = wr_en_i && (wr_addr_i == A_CTRL);
  assign en_rise  = ctrl_wr && wr_data_i[0] && !ctrl_q.en;
  assign cause_rd = rd_en_i && (rd_addr_i == A_CAUSE);

  evt_sync_edge #(.STAGES(2)) u_sync (
    .clk_i, .rst_ni,
    .pin_i     (evt_pin_i),
    .fall_sel_i(ctrl_q.pol),
    .evt_o     (pin_evt)
  );

  evt_prescaler #(.NSEL(4), .STEP(2)) u_pre (
    .clk_i, .rst_ni,
    .run_i (ctrl_q.en && !ctrl_q.src),
    .sel_i (ctrl_q.psel),
    .tick_o(pre_tick)
  );

  assign dec     = ctrl_q.en && !ctrl_wr && (ctrl_q.src ? pin_evt : pre_tick);
  assign term    = (cnt_q <= W'(1));
  assign eoc_set = dec && term;

  evt_cause_flags #(.N(NCAUSE)) u_cause (
    .clk_i, .rst_ni,
    .set_i  (eoc_set),
    .clr_i  (cause_rd),
    .mask_i (ctrl_q.ie),
    .flags_o(cause),
    .irq_o  (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      reld_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_en_i && (wr_addr_i == A_RELD)) reld_q <= wr_data_i;
      if (ctrl_wr) begin
        ctrl_q <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
        if (en_rise) cnt_q <= reld_q;
      end else if (dec) begin
        if (!term)            cnt_q <= cnt_q - 1'b1;
        else if (ctrl_q.cont) cnt_q <= reld_q;
        else begin
          cnt_q     <= '0;
          ctrl_q.en <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    unique case (reg_addr_e'(rd_addr_i))
      A_CTRL:  rd_data_o = W'(ctrl_q);
      A_RELD:  rd_data_o = reld_q;
      A_COUNT: rd_data_o = cnt_q;
      A_CAUSE: rd_data_o = W'(cause);
      default: rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/evt_reload_timer_chk.sv
module evt_reload_timer_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         irq_o,
  input logic         cause_rd,
  input logic         eoc_set,
  input logic         en_rise,
  input logic         ctrl_wr,
  input logic         en,
  input logic         src,
  input logic         cont,
  input logic         pin_evt,
  input logic [W-1:0] cnt,
  input logic [W-1:0] reld,
  input logic [0:0]   cause
);
  // R3: enabling write loads reload value
  a_r3_load_on_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_rise |=> cnt == $past(reld));

  // R5: pin mode without an edge holds the count
  a_r5_pin_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && src && !pin_evt && !ctrl_wr) |=> $stable(cnt));

  // R9: one-shot expiry clears enable
  a_r9_oneshot_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoc_set && !cont) |=> (!en && cnt == '0));

  // R10: cause raised in a read cycle stays pending
  a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_set |=> cause[0]);

  // R11: clearing read without new cause drops irq
  a_r11_irq_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_rd && !eoc_set) |=> !irq_o);

  // R8: continuous end-of-count reloads
  a_r8_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoc_set && cont) |=> cnt == $past(reld));
endmodule

bind evt_reload_timer evt_reload_timer_chk #(.W(W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .irq_o   (irq_o),
  .cause_rd(cause_rd),
  .eoc_set (eoc_set),
  .en_rise (en_rise),
  .ctrl_wr (ctrl_wr),
  .en      (ctrl_q.en),
  .src     (ctrl_q.src),
  .cont    (ctrl_q.cont),
  .pin_evt (pin_evt),
  .cnt     (cnt_q),
  .reld    (reld_q),
  .cause   (cause)
);

// File: tb/evt_reload_timer_tb_top.sv
`timescale 1ns/100ps
module evt_reload_timer_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        evt_pin_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        rd_en_i = 1'b0;
  logic [1:0]  rd_addr_i = '0;
  logic [15:0] rd_data_o;
  logic        irq_o;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk_i = ~clk_i;

  evt_reload_timer dut_i (.*);

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] d);
    rd_addr_i = a; #0.5; d = rd_data_o;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk_i);
    rd_en_i = 1'b1; rd_addr_i = a; #0.5; d = rd_data_o;
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    for (int a = 0; a < 4; a++) begin
      peek(2'(a), d); chk("R1 reset reg", d, 16'h0);
    end
    chk("R1 reset irq", 16'(irq_o), 16'h0);
  endtask

  task automatic t_prescale;
    logic [15:0] d;
    wr(2'd1, 16'd3);
    wr(2'd0, 16'h0019);                     // en|cont|ie, div4
    peek(2'd2, d); chk("R3 load", d, 16'd3);
    repeat (3) @(negedge clk_i);
    peek(2'd2, d); chk("R4 div4 before", d, 16'd3);
    @(negedge clk_i); peek(2'd2, d); chk("R4 div4 first", d, 16'd2);
    repeat (4) @(negedge clk_i); peek(2'd2, d); chk("R4 div4 second", d, 16'd1);
    chk("R11 irq idle", 16'(irq_o), 16'h0);
    repeat (4) @(negedge clk_i); peek(2'd2, d); chk("R8 reload", d, 16'd3);
    chk("R11 irq set", 16'(irq_o), 16'h1);
    rd(2'd3, d); chk("R10 cause read", d, 16'h1);
    chk("R11 irq cleared", 16'(irq_o), 16'h0);
    peek(2'd3, d); chk("R10 cause cleared", d, 16'h0);
    wr(2'd0, 16'h0);
    wr(2'd1, 16'd2);
    wr(2'd0, 16'h0029);                     // div16
    repeat (15) @(negedge clk_i); peek(2'd2, d); chk("R4 div16 before", d, 16'd2);
    @(negedge clk_i); peek(2'd2, d); chk("R4 div16 first", d, 16'd1);
    wr(2'd0, 16'h0);
  endtask

  task automatic t_pin;
    logic [15:0] d;
    wr(2'd1, 16'd5);
    wr(2'd0, 16'h000B);                     // en|src|cont, rising
    repeat (300) @(negedge clk_i);
    peek(2'd2, d); chk("R5 idle pin holds", d, 16'd5);
    evt_pin_i = 1'b1;
    repeat (2) @(negedge clk_i); peek(2'd2, d); chk("R7 not before edge3", d, 16'd5);
    @(negedge clk_i); peek(2'd2, d); chk("R7 at edge3", d, 16'd4);
    evt_pin_i = 1'b0;
    repeat (4) @(negedge clk_i); peek(2'd2, d); chk("R6 falling ignored", d, 16'd4);
    wr(2'd0, 16'h0);
    wr(2'd0, 16'h000F);                     // falling edge
    evt_pin_i = 1'b1;
    repeat (4) @(negedge clk_i); peek(2'd2, d); chk("R6 rising ignored", d, 16'd5);
    evt_pin_i = 1'b0;
    repeat (3) @(negedge clk_i); peek(2'd2, d); chk("R6 falling counted", d, 16'd4);
    wr(2'd2, 16'hABCD);
    wr(2'd3, 16'h0001);
    peek(2'd2, d); chk("R2 count write ignored", d, 16'd4);
    peek(2'd3, d); chk("R2 cause write ignored", d, 16'h0);
    wr(2'd0, 16'h0);
  endtask

  task automatic t_oneshot;
    logic [15:0] d;
    wr(2'd1, 16'd2);
    wr(2'd0, 16'h0013);                     // en|src|ie, one-shot
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i); evt_pin_i = 1'b1;
      repeat (2) @(negedge clk_i); evt_pin_i = 1'b0;
      repeat (3) @(negedge clk_i);
    end
    peek(2'd2, d); chk("R9 count stays 0", d, 16'd0);
    peek(2'd0, d); chk("R9 enable cleared", d, 16'h0012);
    chk("R11 irq oneshot", 16'(irq_o), 16'h1);
    rd(2'd3, d); chk("R8 cause oneshot", d, 16'h1);
    wr(2'd0, 16'h0);
  endtask

  task automatic t_collide;
    logic [15:0] d;
    wr(2'd1, 16'd1);
    wr(2'd0, 16'h000B);                     // continuous, irq masked
    evt_pin_i = 1'b1;
    @(negedge clk_i); @(negedge clk_i);
    rd_en_i = 1'b1; rd_addr_i = 2'd3; #0.5;
    chk("R10 read before eoc", rd_data_o, 16'h0);
    @(negedge clk_i); rd_en_i = 1'b0;
    peek(2'd3, d); chk("R10 set survives clear", d, 16'h1);
    chk("R11 masked irq", 16'(irq_o), 16'h0);
    wr(2'd0, 16'h001B);                     // unmask, enable already set
    chk("R11 unmask irq", 16'(irq_o), 16'h1);
    peek(2'd2, d); chk("R3 no reload w/o rise", d, 16'd1);
    rd(2'd3, d); chk("R10 cause collide", d, 16'h1);
    chk("R11 irq drop", 16'(irq_o), 16'h0);
    evt_pin_i = 1'b0;
    wr(2'd0, 16'h0);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_prescale();
    t_pin();
    t_oneshot();
    t_collide();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule